// File: doc/BRIEF.md
# Decoded Micro-op Trace Cache Front End

This block sits between an instruction decoder and an execution back end. It keeps already-decoded micro-ops in short trace lines. Each line follows the dynamic path the program is predicted to take, so a line can run straight through a taken branch. The block looks up a line by the exact fetch address that starts it. A hit puts the block in deliver mode: the stored micro-ops stream to the execution port one per cycle, and the lookup involves no address translation. A miss puts it in build mode: the block asks the decoder for micro-ops at a fetch address it drives, packs them into a segment, and writes the segment into the cache. It then looks the segment up again and delivers it.

Some micro-ops carry a microcode marker, and their payload's low bits index a small internal sequence ROM. The marker itself never reaches the execution port. In its place the ROM entries are emitted, from the index up to the end of that sequence, and delivery then carries on with the trace after the marker. A flush input, used on a branch misprediction, abandons whatever is in progress and restarts lookup at a redirect address.

Both data paths use valid/ready. On the execution port, a micro-op offered with `ex_valid_o` stays on the port, unchanged, until `ex_ready_i` is seen high at a clock edge. The only exception is a flush, which withdraws it. On the decoder port, an op is taken only at an edge where `dec_valid_i` and `dec_ready_o` are both high. The block may hold `dec_ready_o` low for an op it will not put in the current segment.

Top module: `tc_front`

## Requirements
- R1: After reset no line is valid and `ex_valid_o` is low. The first lookup, at START_PC (default 0x010), misses. In the first cycle after the first clock edge, `build_mode_o` is high and `dec_pc_o` equals START_PC.
- R2: A segment closes once it holds LINE_UOPS (6) micro-ops. The next segment starts at the address that follows the last op taken.
- R3: A branch op is stored inside the segment. The next fetch address is `dec_tgt_pc_i` if the op is marked predicted-taken, and `dec_fall_pc_i` otherwise.
- R4: If a segment already holds a branch and the decoder offers a second one, `dec_ready_o` stays low for that op and the segment closes without it. The next segment starts at that branch's address.
- R5: An op carrying the microcode marker is stored as the last op of its segment, and the segment closes right after it.
- R6: In delivery a marked op is not emitted. ROM entries from index payload[3:0] are emitted instead, each with payload {4'hF, 12-bit index}, up to and including the first entry whose index mod 4 equals 3 (or the final ROM entry). Delivery then resumes with the op after the marker.
- R7: Ops from the ROM use the same execution port, with the branch and predicted-taken flags low.
- R8: A flush to the start address of a stored line hits. `ex_valid_o` is high with the line's first op in the second cycle after the flush edge, and no build is started.
- R9: The stream at the execution port equals the decoder's ops in predicted program order (with R6 expansion), whatever the segment boundaries.
- R10: While `ex_ready_i` is low, an offered op stays valid and unchanged. Back-pressure never drops or repeats an op.
- R11: A flush aborts a build in progress and discards the partial segment. A later lookup of that segment's start misses and builds again.
- R12: Lookup is direct-mapped on fetch address bits [3:0] (16 lines). A segment built at another address with the same low bits replaces the line that was there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Abort current activity and restart lookup |
| redirect_pc_i | input | PC_W | Lookup address used with a flush |
| dec_valid_i | input | 1 | Decoder offers an op for `dec_pc_o` |
| dec_ready_o | output | 1 | Block takes the offered op |
| dec_payload_i | input | UOP_W | Opaque op payload (ROM index in low bits for marked ops) |
| dec_is_br_i | input | 1 | Op is a branch |
| dec_taken_i | input | 1 | Branch predicted taken |
| dec_ucode_i | input | 1 | Op carries the microcode marker |
| dec_tgt_pc_i | input | PC_W | Branch target address |
| dec_fall_pc_i | input | PC_W | Address following the op |
| dec_pc_o | output | PC_W | Address the decoder must supply next |
| build_mode_o | output | 1 | Block is collecting a segment |
| ex_valid_o | output | 1 | Execution op offered |
| ex_ready_i | input | 1 | Execution side accepts |
| ex_payload_o | output | UOP_W | Op payload |
| ex_is_br_o | output | 1 | Op is a branch |
| ex_taken_o | output | 1 | Branch predicted taken |

## Verification
The bench builds the same address range several ways. It uses straight code, a taken branch followed by a second branch, a not-taken branch, and marked ops that point near and at the end of the ROM. It compares both the delivered stream and the sequence of segment start addresses against a model of the closing rules. A design that takes the second branch into the segment, or closes after the marker instead of at it, gets the start addresses wrong. A design that steps to the fall-through after a taken branch corrupts the stream. A design that emits the marker or stops the ROM early shows up as wrong payloads. Flushes into a partly built segment and into an aliasing address check that a partial segment never becomes a hit and that an evicted line misses. A stall pattern on `ex_ready_i` exposes any op that is skipped or duplicated under back-pressure.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [2:0] {
    S_LOOK  = 3'd0,
    S_BUILD = 3'd1,
    S_WRITE = 3'd2,
    S_DELIV = 3'd3,
    S_ROM   = 3'd4
  } tc_state_t;

  typedef struct packed {
    logic is_br;
    logic taken;
    logic ucode;
  } uop_flags_t;
endpackage

// File: rtl/tc_seq_rom.sv
module tc_seq_rom #(
  parameter int UOP_W     = 16,
  parameter int ROM_DEPTH = 16,
  parameter int SEQ_LEN   = 4,
  parameter int ROM_AW    = $clog2(ROM_DEPTH)
) (
  input  logic [ROM_AW-1:0] addr,
  output logic [UOP_W-1:0]  data,
  output logic              last
);
  logic [ROM_DEPTH-1:0] end_mark;

  // an entry ends its sequence at each SEQ_LEN boundary and at the top
  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_end
    assign end_mark[g] = ((g % SEQ_LEN) == SEQ_LEN - 1) || (g == ROM_DEPTH - 1);
  end

  assign data = {4'hF, (UOP_W-4)'(addr)};
  assign last = end_mark[addr];
endmodule

// File: rtl/tc_line_store.sv
module tc_line_store
  import tc_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int UOP_W     = 16,
  parameter int LINES     = 16,
  parameter int LINE_UOPS = 6,
  parameter int IDX_W     = $clog2(LINES),
  parameter int CNT_W     = $clog2(LINE_UOPS + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [PC_W-1:0]                   lk_pc,
  output logic                              lk_hit,
  input  logic [IDX_W-1:0]                  rd_line,
  input  logic [CNT_W-1:0]                  rd_slot,
  output logic [UOP_W-1:0]                  rd_pay,
  output uop_flags_t                        rd_flg,
  output logic [CNT_W-1:0]                  rd_cnt,
  output logic [PC_W-1:0]                   rd_next,
  input  logic                              wr_en,
  input  logic [PC_W-1:0]                   wr_pc,
  input  logic [CNT_W-1:0]                  wr_cnt,
  input  logic [PC_W-1:0]                   wr_next,
  input  logic [LINE_UOPS-1:0][UOP_W-1:0]   wr_pay,
  input  uop_flags_t [LINE_UOPS-1:0]        wr_flg
);
  localparam int TAG_W = PC_W - IDX_W;

  logic [LINES-1:0]                 vld_q;
  logic [TAG_W-1:0]                 tag_a [LINES];
  logic [CNT_W-1:0]                 cnt_a [LINES];
  logic [PC_W-1:0]                  nxt_a [LINES];
  logic [LINE_UOPS-1:0][UOP_W-1:0]  pay_a [LINES];
  uop_flags_t [LINE_UOPS-1:0]       flg_a [LINES];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  assign lk_idx = lk_pc[IDX_W-1:0];
  assign wr_idx = wr_pc[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_a[wr_idx] <= wr_pc[PC_W-1:IDX_W];
      cnt_a[wr_idx] <= wr_cnt;
      nxt_a[wr_idx] <= wr_next;
      pay_a[wr_idx] <= wr_pay;
      flg_a[wr_idx] <= wr_flg;
    end
  end

  assign lk_hit  = vld_q[lk_idx] && (tag_a[lk_idx] == lk_pc[PC_W-1:IDX_W]);
  assign rd_pay  = pay_a[rd_line][rd_slot];
  assign rd_flg  = flg_a[rd_line][rd_slot];
  assign rd_cnt  = cnt_a[rd_line];
  assign rd_next = nxt_a[rd_line];
endmodule

// File: rtl/tc_front.sv
module tc_front
  import tc_pkg::*;
#(
  parameter int              PC_W      = 12,
  parameter int              UOP_W     = 16,
  parameter int              LINES     = 16,
  parameter int              LINE_UOPS = 6,
  parameter int              ROM_DEPTH = 16,
  parameter int              SEQ_LEN   = 4,
  parameter logic [PC_W-1:0] START_PC  = 'h010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [PC_W-1:0]  redirect_pc_i,
  input  logic             dec_valid_i,
  output logic             dec_ready_o,
  input  logic [UOP_W-1:0] dec_payload_i,
  input  logic             dec_is_br_i,
  input  logic             dec_taken_i,
  input  logic             dec_ucode_i,
  input  logic [PC_W-1:0]  dec_tgt_pc_i,
  input  logic [PC_W-1:0]  dec_fall_pc_i,
  output logic [PC_W-1:0]  dec_pc_o,
  output logic             build_mode_o,
  output logic             ex_valid_o,
  input  logic             ex_ready_i,
  output logic [UOP_W-1:0] ex_payload_o,
  output logic             ex_is_br_o,
  output logic             ex_taken_o
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int CNT_W  = $clog2(LINE_UOPS + 1);
  localparam int ROM_AW = $clog2(ROM_DEPTH);

  tc_state_t                       st_q;
  logic [PC_W-1:0]                 pc_q, seg_start_q, fetch_q;
  logic [IDX_W-1:0]                line_q;
  logic [CNT_W-1:0]                slot_q, seg_cnt_q;
  logic [ROM_AW-1:0]               rom_q;
  logic                            seg_br_q;
  logic [LINE_UOPS-1:0][UOP_W-1:0] seg_pay_q;
  uop_flags_t [LINE_UOPS-1:0]      seg_flg_q;

  logic             lk_hit, rom_last, last_slot, second_br, dec_acc, wr_en;
  logic [UOP_W-1:0] rd_pay, rom_data;
  uop_flags_t       rd_flg;
  logic [CNT_W-1:0] rd_cnt;
  logic [PC_W-1:0]  rd_next;

  tc_line_store #(
    .PC_W(PC_W), .UOP_W(UOP_W), .LINES(LINES), .LINE_UOPS(LINE_UOPS)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(pc_q), .lk_hit(lk_hit),
    .rd_line(line_q), .rd_slot(slot_q),
    .rd_pay(rd_pay), .rd_flg(rd_flg), .rd_cnt(rd_cnt), .rd_next(rd_next),
    .wr_en(wr_en), .wr_pc(seg_start_q), .wr_cnt(seg_cnt_q), .wr_next(fetch_q),
    .wr_pay(seg_pay_q), .wr_flg(seg_flg_q)
  );

  tc_seq_rom #(
    .UOP_W(UOP_W), .ROM_DEPTH(ROM_DEPTH), .SEQ_LEN(SEQ_LEN)
  ) u_rom (
    .addr(rom_q), .data(rom_data), .last(rom_last)
  );

  assign wr_en        = (st_q == S_WRITE);
  assign build_mode_o = (st_q == S_BUILD);
  assign dec_pc_o     = fetch_q;
  assign second_br    = dec_is_br_i && seg_br_q;
  assign dec_ready_o  = build_mode_o && !second_br;
  assign dec_acc      = dec_valid_i && dec_ready_o;
  assign last_slot    = (slot_q + CNT_W'(1)) == rd_cnt;

  always_comb begin
    ex_valid_o   = (st_q == S_ROM) || ((st_q == S_DELIV) && !rd_flg.ucode);
    ex_payload_o = (st_q == S_ROM) ? rom_data : rd_pay;
    ex_is_br_o   = (st_q == S_DELIV) && rd_flg.is_br;
    ex_taken_o   = (st_q == S_DELIV) && rd_flg.taken;
  end

  // segment buffer carries no reset: only slots below seg_cnt_q are used
  always_ff @(posedge clk) begin
    if (dec_acc) begin
      seg_pay_q[seg_cnt_q] <= dec_payload_i;
      seg_flg_q[seg_cnt_q] <= '{is_br: dec_is_br_i, taken: dec_taken_i, ucode: dec_ucode_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_LOOK;
      pc_q        <= START_PC;
      line_q      <= '0;
      slot_q      <= '0;
      rom_q       <= '0;
      seg_start_q <= '0;
      fetch_q     <= '0;
      seg_cnt_q   <= '0;
      seg_br_q    <= 1'b0;
    end else if (flush_i) begin
      st_q <= S_LOOK;
      pc_q <= redirect_pc_i;
    end else begin
      unique case (st_q)
        S_LOOK: begin
          if (lk_hit) begin
            st_q   <= S_DELIV;
            line_q <= pc_q[IDX_W-1:0];
            slot_q <= '0;
          end else begin
            st_q        <= S_BUILD;
            seg_start_q <= pc_q;
            fetch_q     <= pc_q;
            seg_cnt_q   <= '0;
            seg_br_q    <= 1'b0;
          end
        end
        S_BUILD: begin
          if (dec_valid_i && second_br) begin
            st_q <= S_WRITE;
          end else if (dec_acc) begin
            seg_cnt_q <= seg_cnt_q + CNT_W'(1);
            seg_br_q  <= seg_br_q | dec_is_br_i;
            fetch_q   <= (dec_is_br_i && dec_taken_i) ? dec_tgt_pc_i : dec_fall_pc_i;
            if (dec_ucode_i || (seg_cnt_q == CNT_W'(LINE_UOPS - 1))) st_q <= S_WRITE;
          end
        end
        S_WRITE: begin
          st_q <= S_LOOK;
          pc_q <= seg_start_q;
        end
        S_DELIV: begin
          if (rd_flg.ucode) begin
            st_q  <= S_ROM;
            rom_q <= rd_pay[ROM_AW-1:0];
          end else if (ex_ready_i) begin
            if (last_slot) begin
              st_q <= S_LOOK;
              pc_q <= rd_next;
            end else begin
              slot_q <= slot_q + CNT_W'(1);
            end
          end
        end
        S_ROM: begin
          if (ex_ready_i) begin
            if (!rom_last) begin
              rom_q <= rom_q + ROM_AW'(1);
            end else if (last_slot) begin
              st_q <= S_LOOK;
              pc_q <= rd_next;
            end else begin
              st_q   <= S_DELIV;
              slot_q <= slot_q + CNT_W'(1);
            end
          end
        end
        default: st_q <= S_LOOK;
      endcase
    end
  end
endmodule

// File: rtl/tc_front_chk.sv
module tc_front_chk
  import tc_pkg::*;
#(
  parameter int UOP_W     = 16,
  parameter int LINE_UOPS = 6,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic             dec_valid_i,
  input logic             dec_ready_o,
  input logic             dec_is_br_i,
  input logic             build_mode_o,
  input logic             ex_valid_o,
  input logic             ex_ready_i,
  input logic [UOP_W-1:0] ex_payload_o,
  input tc_state_t        st,
  input logic             lk_hit,
  input logic             rom_last,
  input logic             seg_br,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_cnt
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid_o && !ex_ready_i && !flush_i) |=> (ex_valid_o && $stable(ex_payload_o)));

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!ex_valid_o && !build_mode_o));

  p_build_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(build_mode_o) |-> $past(st == S_LOOK && !lk_hit));

  p_hit_to_deliver_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK && lk_hit && !flush_i) |=> (st == S_DELIV));

  p_line_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_cnt != '0 && wr_cnt <= CNT_W'(LINE_UOPS)));

  p_second_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (build_mode_o && dec_valid_i && dec_is_br_i && seg_br) |-> !dec_ready_o);

  p_rom_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ROM && ex_ready_i && rom_last && !flush_i) |=> (st != S_ROM));
endmodule

bind tc_front tc_front_chk #(
  .UOP_W(UOP_W), .LINE_UOPS(LINE_UOPS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
  .dec_valid_i(dec_valid_i), .dec_ready_o(dec_ready_o), .dec_is_br_i(dec_is_br_i),
  .build_mode_o(build_mode_o), .ex_valid_o(ex_valid_o), .ex_ready_i(ex_ready_i),
  .ex_payload_o(ex_payload_o), .st(st_q), .lk_hit(lk_hit), .rom_last(rom_last),
  .seg_br(seg_br_q), .wr_en(wr_en), .wr_cnt(seg_cnt_q)
);

// File: tb/tc_front_tb.sv
module tc_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [11:0] redirect_pc_i = '0;
  logic        dec_valid_i = 1'b0;
  logic        dec_ready_o;
  logic [15:0] dec_payload_i = '0;
  logic        dec_is_br_i = 1'b0, dec_taken_i = 1'b0, dec_ucode_i = 1'b0;
  logic [11:0] dec_tgt_pc_i = '0, dec_fall_pc_i = '0;
  logic [11:0] dec_pc_o;
  logic        build_mode_o, ex_valid_o;
  logic        ex_ready_i = 1'b1;
  logic [15:0] ex_payload_o;
  logic        ex_is_br_o, ex_taken_o;

  always #10 clk = ~clk;

  tc_front u_dut (.*);

  // program model
  bit       br_at [4096];
  bit       tk_at [4096];
  bit       uc_at [4096];
  bit [3:0] ri_at [4096];

  // observation
  logic [17:0] got [64];
  logic [11:0] bst [64];
  int ngot = 0, nb = 0;
  logic [17:0] exp_s [64];
  logic [11:0] exp_b [64];
  bit   stall = 1'b0;
  bit   prev_bm = 1'b0;
  int   cyc = 0;
  int   n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // decoder model
  initial begin
    forever begin
      @(negedge clk);
      dec_valid_i   = build_mode_o;
      dec_is_br_i   = br_at[dec_pc_o];
      dec_taken_i   = tk_at[dec_pc_o];
      dec_ucode_i   = uc_at[dec_pc_o];
      dec_payload_i = uc_at[dec_pc_o] ? {12'h000, ri_at[dec_pc_o]} : {4'h0, dec_pc_o};
      dec_tgt_pc_i  = dec_pc_o + 12'h100;
      dec_fall_pc_i = dec_pc_o + 12'h001;
    end
  end

  // execution sink, build monitor and watchdog
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      ex_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (rst_n && !flush_i) begin
        if (ex_valid_o && ex_ready_i && ngot < 64) begin
          got[ngot] = {ex_is_br_o, ex_taken_o, ex_payload_o};
          ngot++;
        end
        if (build_mode_o && !prev_bm && nb < 64) begin
          bst[nb] = dec_pc_o;
          nb++;
        end
      end
      prev_bm = build_mode_o;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic clear_prog();
    for (int i = 0; i < 4096; i++) begin
      br_at[i] = 0; tk_at[i] = 0; uc_at[i] = 0; ri_at[i] = '0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    stall = 1'b0;
    repeat (3) @(negedge clk);
    ngot = 0; nb = 0;
    rst_n = 1'b1;
  endtask

  task automatic do_flush(input logic [11:0] a);
    @(negedge clk);
    flush_i = 1'b1; redirect_pc_i = a;
    ngot = 0; nb = 0;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  task automatic wait_got(input string req, input int n);
    int t = 0;
    while (ngot < n && t < 3000) begin
      @(negedge clk); t++;
    end
    chk(req, (ngot >= n), 1);
  endtask

  task automatic model_stream(input logic [11:0] s, input int n);
    logic [11:0] pc = s;
    int k = 0;
    while (k < n) begin
      if (uc_at[pc]) begin
        int r = ri_at[pc];
        bit done = 0;
        while (!done && k < n) begin
          exp_s[k] = {2'b00, 4'hF, 8'h00, 4'(r)};
          k++;
          done = ((r % 4) == 3) || (r == 15);
          r++;
        end
        pc = pc + 12'h001;
      end else begin
        exp_s[k] = {br_at[pc], tk_at[pc], 4'h0, pc};
        k++;
        pc = (br_at[pc] && tk_at[pc]) ? pc + 12'h100 : pc + 12'h001;
      end
    end
  endtask

  task automatic model_starts(input logic [11:0] s, input int n);
    logic [11:0] pc = s;
    for (int k = 0; k < n; k++) begin
      int  cnt = 0;
      bit  hb = 0, closed = 0;
      exp_b[k] = pc;
      while (!closed) begin
        if (br_at[pc] && hb) begin
          closed = 1;
        end else begin
          cnt++;
          hb = hb | br_at[pc];
          closed = (cnt == 6) || uc_at[pc];
          pc = (br_at[pc] && tk_at[pc]) ? pc + 12'h100 : pc + 12'h001;
        end
      end
    end
  endtask

  task automatic cmp_stream(input string req, input int n);
    for (int i = 0; i < n; i++) chk(req, {14'h0, got[i]}, {14'h0, exp_s[i]});
  endtask

  task automatic cmp_starts(input string req, input int n);
    chk(req, (nb >= n), 1);
    for (int i = 0; i < n; i++) chk(req, {20'h0, bst[i]}, {20'h0, exp_b[i]});
  endtask

  // scenarios
  task automatic t_reset();
    clear_prog();
    do_reset();
    chk("R1 ex_valid low", {31'h0, ex_valid_o}, 0);
    chk("R1 not building yet", {31'h0, build_mode_o}, 0);
    @(negedge clk);
    chk("R1 first lookup misses", {31'h0, build_mode_o}, 1);
    chk("R1 fetch at start", {20'h0, dec_pc_o}, 32'h010);
    chk("R1 nothing delivered", {31'h0, ex_valid_o}, 0);
  endtask

  task automatic t_straight();
    clear_prog();
    do_reset();
    wait_got("R9 straight count", 14);
    model_stream(12'h010, 14);
    cmp_stream("R9 straight stream", 14);
    model_starts(12'h010, 3);
    cmp_starts("R2 six-op segments", 3);
  endtask

  task automatic t_branch();
    clear_prog();
    br_at[12'h012] = 1; tk_at[12'h012] = 1;
    br_at[12'h113] = 1;
    br_at[12'h115] = 1; tk_at[12'h115] = 1;
    do_reset();
    wait_got("R3 branch count", 12);
    model_stream(12'h010, 12);
    cmp_stream("R3 predicted path stream", 12);
    model_starts(12'h010, 3);
    cmp_starts("R4 second branch starts segment", 3);
  endtask

  task automatic t_ucode();
    clear_prog();
    uc_at[12'h013] = 1; ri_at[12'h013] = 4'd5;
    uc_at[12'h016] = 1; ri_at[12'h016] = 4'd14;
    do_reset();
    wait_got("R6 ucode count", 12);
    model_stream(12'h010, 12);
    cmp_stream("R6 rom expansion", 12);
    chk("R7 rom op flags low", {30'h0, got[3][17:16]}, 0);
    chk("R7 rom op payload", {16'h0, got[3][15:0]}, 32'hF005);
    model_starts(12'h010, 3);
    cmp_starts("R5 marker closes segment", 3);
  endtask

  task automatic t_hit_stall();
    clear_prog();
    do_reset();
    wait_got("R8 first build", 6);
    do_flush(12'h010);
    chk("R8 lookup cycle", {31'h0, ex_valid_o}, 0);
    @(negedge clk);
    #1;
    chk("R8 hit valid", {31'h0, ex_valid_o}, 1);
    chk("R8 hit payload", {16'h0, ex_payload_o}, 32'h0010);
    chk("R8 no build on hit", {31'h0, build_mode_o}, 0);
    do_flush(12'h010);
    stall = 1'b1;
    wait_got("R10 stalled count", 6);
    stall = 1'b0;
    chk("R8 no build during line", nb, 0);
    model_stream(12'h010, 6);
    cmp_stream("R10 stream under stall", 6);
  endtask

  task automatic t_flush_partial();
    clear_prog();
    do_reset();
    repeat (3) @(negedge clk);
    chk("R11 mid build", {31'h0, build_mode_o}, 1);
    do_flush(12'h400);
    chk("R11 build aborted", {31'h0, build_mode_o}, 0);
    repeat (2) @(negedge clk);
    do_flush(12'h010);
    @(negedge clk);
    chk("R11 partial discarded", {31'h0, build_mode_o}, 1);
    chk("R11 rebuild start", {20'h0, dec_pc_o}, 32'h010);
  endtask

  task automatic t_alias();
    clear_prog();
    do_reset();
    wait_got("R12 build A", 6);
    do_flush(12'h020);
    wait_got("R12 build B", 6);
    do_flush(12'h020);
    @(negedge clk);
    #1;
    chk("R12 B hits", {31'h0, ex_valid_o}, 1);
    do_flush(12'h010);
    @(negedge clk);
    chk("R12 A evicted", {31'h0, build_mode_o}, 1);
    chk("R12 A rebuild start", {20'h0, dec_pc_o}, 32'h010);
  endtask

  initial begin
    t_reset();
    t_straight();
    t_branch();
    t_ucode();
    t_hit_stall();
    t_flush_partial();
    t_alias();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule